// File: doc/BRIEF.md
# Wave-Ordered Memory Request Sequencer

Dataflow processing elements issue loads, stores and memory no-ops in whatever order their operands become ready. This block collects those requests in a small buffer and hands them to a synchronous data array in program order. It rebuilds that order from the ordering link that each request carries. A link holds the request's own sequence number and the sequence numbers of its predecessor and successor. Either neighbour may be unknown.

A buffered request is released only when its link proves that it directly follows the last request released. Requests are grouped into waves by a wave number. The block works through one wave at a time. It moves on to the next wave once a request whose successor field holds the end marker has been released. Loads answer on a response port with their wave and sequence tags. Stores write the array. No-ops take part in ordering but touch nothing.

Field encodings (4-bit link fields): the value 15 is the wildcard, meaning unknown, in either neighbour field. The value 14 in the successor field marks the end of a wave. Valid sequence numbers are 0 to 13. Operation codes are 0 for load, 1 for store and 2 for no-op.

Top module: `wo_seq`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` is 0, `err_o` is 0, and the current wave is 0.
- R2: In a wave where nothing has yet been released, only a request that carries the current wave, a wildcard predecessor and sequence number 0 may be released. Until that request arrives, nothing is released.
- R3: Once an operation M has been released, a buffered request of the current wave whose sequence number equals M's successor field is released next.
- R4: When M's successor field is the wildcard, a buffered request of the current wave whose predecessor field equals M's sequence number is released next.
- R5: Releasing a request whose successor field is the end marker (14) advances the current wave by one. Requests of later waves stay buffered until that happens.
- R6: A released load (op 0) raises `rsp_valid_o` for one cycle, one clock after release. The response carries the request's wave and sequence number, and the array word at its address, which includes every store released earlier.
- R7: A released no-op (op 2) writes nothing and produces no response.
- R8: A released store (op 1) writes its data at its address and produces no response.
- R9: With 16 requests buffered, `req_ready_o` is 0.
- R10: `err_o` becomes 1 and stays 1 until reset when all of the following hold: the buffer is full, nothing can be released, the last released successor is the wildcard, and a current-wave request with a wildcard predecessor is waiting. This condition is a wildcard-to-wildcard adjacency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Buffer can take a request |
| req_wave_i | input | 4 | Wave number |
| req_pred_i | input | 4 | Predecessor sequence number or wildcard |
| req_seq_i | input | 4 | Own sequence number |
| req_succ_i | input | 4 | Successor sequence number, wildcard or end marker |
| req_op_i | input | 2 | 0 load, 1 store, 2 no-op |
| req_addr_i | input | 4 | Word address |
| req_wdata_i | input | 8 | Store data |
| rsp_valid_o | output | 1 | Load response present |
| rsp_wave_o | output | 4 | Wave of the answered load |
| rsp_seq_o | output | 4 | Sequence number of the answered load |
| rsp_rdata_o | output | 8 | Loaded word |
| err_o | output | 1 | Sticky ordering error |

## Verification
Three waves are sent fully scrambled, with the opening request of wave 0 held back until last. This shows that arrival order never leaks into issue order and that nothing is released before a wave's head is present.

The waves mix successor-matched steps, wildcard-successor steps resolved through the predecessor field, and a branch that skips sequence numbers. Together these separate the two linking rules from a plain counter.

Store, no-op and load requests to the same word tell a write apart from an ordering-only operation. A buffer filled with far-future waves exercises backpressure. A deliberate wildcard pair with a full buffer raises the error, and the same pair with spare room does not.

// File: rtl/wo_pkg.sv
package wo_pkg;
  localparam int WAVE_W = 4;
  localparam int SEQ_W  = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [SEQ_W-1:0] SEQ_WILD = '1;
  localparam logic [SEQ_W-1:0] SEQ_END  = SEQ_WILD - 1'b1;

  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_NOP = 2'd2} op_e;

  typedef struct packed {
    logic [WAVE_W-1:0] wave;
    logic [SEQ_W-1:0]  pred;
    logic [SEQ_W-1:0]  seq;
    logic [SEQ_W-1:0]  succ;
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } mreq_t;
endpackage

// File: rtl/wo_buffer.sv
module wo_buffer import wo_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  mreq_t                  wr_req_i,
  input  logic                   rd_en_i,
  input  logic [IDX_W-1:0]       rd_idx_i,
  output mreq_t [DEPTH-1:0]      ent_o,
  output logic  [DEPTH-1:0]      vld_o,
  output logic                   full_o
);
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_o[i]) free_idx = IDX_W'(i);
  end

  assign full_o = &vld_o;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic set_s, clr_s;
    assign set_s = wr_en_i && !full_o && (free_idx == IDX_W'(g));
    assign clr_s = rd_en_i && (rd_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    vld_o[g] <= 1'b0;
      else if (set_s) vld_o[g] <= 1'b1;
      else if (clr_s) vld_o[g] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    ent_o[g] <= '0;
      else if (set_s) ent_o[g] <= wr_req_i;
    end
  end
endmodule

// File: rtl/wo_match.sv
module wo_match import wo_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  mreq_t [DEPTH-1:0] ent_i,
  input  logic  [DEPTH-1:0] vld_i,
  input  logic [WAVE_W-1:0] cur_wave_i,
  input  logic              started_i,
  input  logic [SEQ_W-1:0]  last_seq_i,
  input  logic [SEQ_W-1:0]  last_succ_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic              stuck_o
);
  logic [DEPTH-1:0] hit_vec, stk_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic same;
    assign same = vld_i[g] && (ent_i[g].wave == cur_wave_i);
    // wave head, successor link, or predecessor link behind a wildcard successor
    assign hit_vec[g] = same && (started_i
        ? ((last_succ_i != SEQ_WILD && last_succ_i == ent_i[g].seq) ||
           (last_succ_i == SEQ_WILD && ent_i[g].pred == last_seq_i))
        : (ent_i[g].pred == SEQ_WILD && ent_i[g].seq == '0));
    assign stk_vec[g] = same && started_i && last_succ_i == SEQ_WILD &&
                        ent_i[g].pred == SEQ_WILD;
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx_o = IDX_W'(i);
  end

  assign hit_o   = |hit_vec;
  assign stuck_o = |stk_vec;
endmodule

// File: rtl/wo_mem.sv
module wo_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i)
    if (we_i) mem_q[addr_i] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/wo_seq.sv
module wo_seq import wo_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [WAVE_W-1:0] req_wave_i,
  input  logic [SEQ_W-1:0]  req_pred_i,
  input  logic [SEQ_W-1:0]  req_seq_i,
  input  logic [SEQ_W-1:0]  req_succ_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [WAVE_W-1:0] rsp_wave_o,
  output logic [SEQ_W-1:0]  rsp_seq_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              err_o
);
  mreq_t                wr_req, iss;
  mreq_t [DEPTH-1:0]    buf_ent;
  logic  [DEPTH-1:0]    buf_vld;
  logic                 buf_full, hit, stuck, issue;
  logic  [IDX_W-1:0]    hit_idx;
  logic  [WAVE_W-1:0]   cur_wave;
  logic                 started;
  logic  [SEQ_W-1:0]    last_seq, last_succ;

  assign wr_req = '{wave: req_wave_i, pred: req_pred_i, seq: req_seq_i,
                    succ: req_succ_i, op: op_e'(req_op_i), addr: req_addr_i,
                    data: req_wdata_i};
  assign req_ready_o = !buf_full;

  wo_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk_i, .rst_ni, .wr_en_i(req_valid_i), .wr_req_i(wr_req),
    .rd_en_i(issue), .rd_idx_i(hit_idx), .ent_o(buf_ent), .vld_o(buf_vld),
    .full_o(buf_full));

  wo_match #(.DEPTH(DEPTH)) u_match (
    .ent_i(buf_ent), .vld_i(buf_vld), .cur_wave_i(cur_wave),
    .started_i(started), .last_seq_i(last_seq), .last_succ_i(last_succ),
    .hit_o(hit), .hit_idx_o(hit_idx), .stuck_o(stuck));

  assign issue = hit;
  assign iss   = buf_ent[hit_idx];

  wo_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni, .we_i(issue && iss.op == OP_STORE),
    .re_i(issue && iss.op == OP_LOAD), .addr_i(iss.addr),
    .wdata_i(iss.data), .rdata_o(rsp_rdata_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_wave  <= '0;
      started   <= 1'b0;
      last_seq  <= '0;
      last_succ <= SEQ_WILD;
    end else if (issue) begin
      last_seq  <= iss.seq;
      last_succ <= iss.succ;
      if (iss.succ == SEQ_END) begin
        cur_wave <= cur_wave + 1'b1;
        started  <= 1'b0;
      end else begin
        started  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_wave_o  <= '0;
      rsp_seq_o   <= '0;
      err_o       <= 1'b0;
    end else begin
      rsp_valid_o <= issue && iss.op == OP_LOAD;
      if (issue) begin
        rsp_wave_o <= iss.wave;
        rsp_seq_o  <= iss.seq;
      end
      // full, blocked, and only a wildcard-to-wildcard candidate left
      if (buf_full && !hit && stuck) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wo_seq_chk.sv
module wo_seq_chk import wo_pkg::*; #(
  parameter int DEPTH = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic [DEPTH-1:0]  buf_vld,
  input logic              issue,
  input mreq_t             iss,
  input logic [WAVE_W-1:0] cur_wave,
  input logic              rsp_valid_o,
  input logic              err_o
);
  // R9
  no_ready_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> $countones(buf_vld) == DEPTH);
  // R6
  load_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && iss.op == OP_LOAD) |=> rsp_valid_o);
  // R7
  quiet_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && iss.op != OP_LOAD) |=> !rsp_valid_o);
  // R2
  issue_wave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |-> iss.wave == cur_wave);
  // R5
  wave_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && iss.succ == SEQ_END) |=> cur_wave == WAVE_W'($past(cur_wave) + 1'b1));
  // R5
  wave_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(issue && iss.succ == SEQ_END) |=> $stable(cur_wave));
  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind wo_seq wo_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .buf_vld(buf_vld), .issue(issue), .iss(iss), .cur_wave(cur_wave),
  .rsp_valid_o(rsp_valid_o), .err_o(err_o));

// File: tb/wo_seq_test.sv
module wo_seq_test;
  typedef struct packed {
    logic [3:0] wave, pred, seq, succ;
    logic [1:0] op;
    logic [3:0] addr;
    logic [7:0] data;
  } vec_t;
  typedef struct packed { logic [3:0] wave, seq; logic [7:0] data; } exp_t;

  localparam logic [3:0] W = 4'hF, E = 4'hE;
  localparam int NV = 9, NE = 5;
  // scrambled arrival order; wave 0 head arrives last
  localparam vec_t VEC [NV] = '{
    '{4'd1, W,    4'd6, E,    2'd1, 4'd5, 8'hB2},
    '{4'd2, 4'd0, 4'd1, E,    2'd0, 4'd3, 8'h00},
    '{4'd0, 4'd2, 4'd3, E,    2'd0, 4'd3, 8'h00},
    '{4'd0, 4'd0, 4'd1, W,    2'd0, 4'd3, 8'h00},
    '{4'd1, 4'd0, 4'd4, 4'd6, 2'd0, 4'd5, 8'h00},
    '{4'd0, 4'd1, 4'd2, 4'd3, 2'd2, 4'd3, 8'h99},
    '{4'd2, W,    4'd0, 4'd1, 2'd0, 4'd5, 8'h00},
    '{4'd1, W,    4'd0, W,    2'd1, 4'd5, 8'hA1},
    '{4'd0, W,    4'd0, 4'd1, 2'd1, 4'd3, 8'h55}};
  localparam exp_t EXP [NE] = '{
    '{4'd0, 4'd1, 8'h55}, '{4'd0, 4'd3, 8'h55}, '{4'd1, 4'd4, 8'hA1},
    '{4'd2, 4'd0, 8'hB2}, '{4'd2, 4'd1, 8'h55}};

  logic clk = 0, rst_n = 0, req_valid = 0;
  vec_t cur = '0;
  logic req_ready, rsp_valid, err;
  logic [3:0] rsp_wave, rsp_seq;
  logic [7:0] rsp_rdata;
  int checks = 0, fails = 0, nrsp = 0;
  exp_t got [8];

  always #2.5 clk = ~clk;

  wo_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_wave_i(cur.wave), .req_pred_i(cur.pred), .req_seq_i(cur.seq),
    .req_succ_i(cur.succ), .req_op_i(cur.op), .req_addr_i(cur.addr),
    .req_wdata_i(cur.data), .rsp_valid_o(rsp_valid), .rsp_wave_o(rsp_wave),
    .rsp_seq_o(rsp_seq), .rsp_rdata_o(rsp_rdata), .err_o(err));

  always @(negedge clk)
    if (rsp_valid && nrsp < 8) begin
      got[nrsp] = '{rsp_wave, rsp_seq, rsp_rdata};
      nrsp++;
    end

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input vec_t v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur = v; req_valid = 1;
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic reset_dut();
    @(negedge clk); rst_n = 0; nrsp = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    reset_dut();
    @(negedge clk);
    check("R1 ready", 32'(req_ready), 1);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 err", 32'(err), 0);

    for (int i = 0; i < NV; i++) begin
      if (i == NV - 1) begin
        idle(4);
        check("R2 nothing before head", nrsp, 0);
      end
      send(VEC[i]);
    end
    idle(20);
    check("R6 R7 R8 response count", nrsp, NE);
    for (int i = 0; i < NE; i++) begin
      // R2 R3 R4 R5 R6 R7 R8: order, tags and data
      check(i == 0 ? "R3" : i == 1 ? "R7" : i == 2 ? "R4" : i == 3 ? "R5" : "R8",
            32'(got[i]), 32'(EXP[i]));
    end

    // R9: fill with a wave that never becomes current
    reset_dut();
    for (int i = 0; i < 15; i++) send('{4'd5, W, 4'd0, 4'd1, 2'd0, 4'd0, 8'h00});
    @(negedge clk);
    check("R9 ready at 15", 32'(req_ready), 1);
    send('{4'd5, W, 4'd0, 4'd1, 2'd0, 4'd0, 8'h00});
    @(negedge clk);
    check("R9 ready at 16", 32'(req_ready), 0);
    check("R9 no release", nrsp, 0);

    // R10: wildcard successor followed by a wildcard predecessor
    reset_dut();
    send('{4'd0, W, 4'd0, W, 2'd2, 4'd0, 8'h00});
    idle(3);
    send('{4'd0, W, 4'd2, E, 2'd0, 4'd1, 8'h00});
    idle(3);
    check("R10 not full", 32'(err), 0);
    for (int i = 0; i < 15; i++) send('{4'd3, W, 4'd0, 4'd1, 2'd0, 4'd0, 8'h00});
    idle(3);
    check("R10 raised", 32'(err), 1);
    idle(10);
    check("R10 sticky", 32'(err), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule